// File: doc/BRIEF.md
# GPIO Port with Edge Detect

An eight-pin general-purpose port on a small synchronous register bus. Each pin can be an input or an output. It can also be handed to an alternate function, which then drives its output value and its enable. The pad outputs and output enables feed a tristate pad, and the pad level comes back on `pad_in`.

The block keeps the value written for output (the output latch) apart from the observed pin level. The pin level is read back after a two-flop synchronizer. A change on the synchronized level can set a sticky per-pin flag. For each pin, the flag can be set by a rising edge, by a falling edge, by both, or by neither. Software clears a flag by writing a one to its bit. The interrupt line is the OR of the flags that a mask enables.

Register selects on `bus_addr`: 0 output latch, 1 direction, 2 pin level (read-only), 3 alternate-function select, 4 rising-edge enable, 5 falling-edge enable, 6 edge flags, 7 interrupt mask. Writes take effect on the rising clock edge while `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_edge_port`

## Requirements
- R1: The reset state has the latch, direction, alternate select, both edge enables, the mask and all flags at 0. It also holds `pad_oe` at 0 and `irq` at 0.
- R2: A write to select 0 stores the latch. On a pin whose alternate bit is 0, `pad_out` carries the latch bit and `pad_oe` carries the direction bit (1 = output). Without a write to select 0, the latch holds.
- R3: A read of select 0 returns the latch contents, whatever level the pins are at.
- R4: A read of select 2 returns the pad level as it was two rising clock edges earlier, for inputs and for driven outputs alike. A write to select 2 changes no register.
- R5: A pin whose bit in select 3 is 1 takes `pad_out` from `alt_out` and `pad_oe` from `alt_oe`. Its level still appears at select 2 and on `alt_in`.
- R6: A flag is set by a synchronized rising transition when the pin's bit in select 4 is 1, and by a falling transition when its bit in select 5 is 1. With both bits set, either transition sets it; with neither set, no transition does. The flag becomes visible at select 6 after the third rising edge following the pad change.
- R7: Flags stay set until a write to select 6 carries a 1 in their bit. Bits written as 0 are left unchanged.
- R8: If a clearing write and a new matching transition on the same pin land on the same clock edge, the flag ends up set.
- R9: `irq` is high exactly when some flag is set whose bit in select 7 is 1.
- R10: Selects 0, 1, 3, 4, 5 and 7 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pad_in | input | 8 | Level seen at the pads |
| pad_out | output | 8 | Value driven to the pads |
| pad_oe | output | 8 | Per-pin output enable |
| alt_out | input | 8 | Alternate-function output values |
| alt_oe | input | 8 | Alternate-function output enables |
| alt_in | output | 8 | Synchronized pin level for the alternate function |
| irq | output | 1 | Masked OR of the edge flags |

## Verification
The bench samples the flags one edge before and on the edge where a transition should first appear. A detector that skipped the synchronizer, or one that compared unsynchronized samples, would show the flag a cycle early. It drives a clearing write on the exact edge where a new falling transition is detected on the same pin; a clear-wins priority would leave that flag at 0. It drives outputs back into the pad model and shows that the latch readback and the pin readback differ, so a design that merged the two views would fail. It also checks that alternate pins keep feeding the pin register, that edge enables choose the direction, that zero bits in a clearing write leave flags alone, and that a masked flag keeps `irq` low.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int PORT_W = 8;

    typedef enum logic [2:0] {
        SEL_LATCH = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_PIN   = 3'd2,
        SEL_ALT   = 3'd3,
        SEL_RISE  = 3'd4,
        SEL_FALL  = 3'd5,
        SEL_FLAG  = 3'd6,
        SEL_MASK  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } bus_req_t;

    // True when the pair of samples forms a transition that the enables select.
    function automatic logic edge_match(input logic rise_en, input logic fall_en,
                                        input logic cur, input logic prev);
        return (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[LAST];

endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] flags_q;
    logic [WIDTH-1:0] flags_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign hit[i]     = edge_match(rise_en[i], fall_en[i], level[i], prev_q[i]);
        // A fresh edge overrides a concurrent clear on the same bit.
        assign flags_d[i] = (flags_q[i] & ~clr_mask[i]) | hit[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            flags_q <= '0;
        end else begin
            prev_q  <= level;
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags_q & ~clr_mask) != '0 |=> (flags_q & $past(flags_q & ~clr_mask)) == $past(flags_q & ~clr_mask)
    ) else $error("flag dropped without clear"); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        hit != '0 |=> (flags_q & $past(hit)) == $past(hit)
    ) else $error("detected edge did not set flag"); // R8

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pin,
    input  logic [WIDTH-1:0] flags,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] latch,
    output logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] alt_sel,
    output logic [WIDTH-1:0] rise_en,
    output logic [WIDTH-1:0] fall_en,
    output logic [WIDTH-1:0] irq_mask,
    output logic [WIDTH-1:0] clr_mask
);
    logic [WIDTH-1:0] latch_q, dir_q, alt_q, rise_q, fall_q, mask_q;
    logic             rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            alt_q   <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            mask_q  <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_LATCH: latch_q <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_ALT:   alt_q   <= wdata;
                SEL_RISE:  rise_q  <= wdata;
                SEL_FALL:  fall_q  <= wdata;
                SEL_MASK:  mask_q  <= wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) rst_q <= rst;

    assign clr_mask = (req.wr && req.sel == SEL_FLAG) ? wdata : '0;

    always_comb begin
        case (req.sel)
            SEL_LATCH: rdata = latch_q;
            SEL_DIR:   rdata = dir_q;
            SEL_PIN:   rdata = pin;
            SEL_ALT:   rdata = alt_q;
            SEL_RISE:  rdata = rise_q;
            SEL_FALL:  rdata = fall_q;
            SEL_FLAG:  rdata = flags;
            SEL_MASK:  rdata = mask_q;
            default:   rdata = '0;
        endcase
    end

    assign latch    = latch_q;
    assign dir      = dir_q;
    assign alt_sel  = alt_q;
    assign rise_en  = rise_q;
    assign fall_en  = fall_q;
    assign irq_mask = mask_q;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == SEL_LATCH) |=> $stable(latch_q)
    ) else $error("latch changed without write"); // R2

    always_ff @(posedge clk) begin
        if (rst_q && !rst) begin
            AST_DIR_CLEARED: assert (dir_q == '0 && alt_q == '0)
                else $error("direction not cleared by reset"); // R1
        end
    end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] alt_sel,
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pad_out[i] = alt_sel[i] ? alt_out[i] : latch[i];
        assign pad_oe[i]  = alt_sel[i] ? alt_oe[i]  : dir[i];
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH     = PORT_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic [WIDTH-1:0] alt_in,
    output logic             irq
);
    bus_req_t         req;
    logic [WIDTH-1:0] pin_lvl, flags;
    logic [WIDTH-1:0] latch, dir, alt_sel, rise_en, fall_en, irq_mask, clr_mask;

    assign req.wr  = bus_wr;
    assign req.sel = reg_sel_e'(bus_addr);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pad_in),
        .dout(pin_lvl)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wdata   (bus_wdata),
        .pin     (pin_lvl),
        .flags   (flags),
        .rdata   (bus_rdata),
        .latch   (latch),
        .dir     (dir),
        .alt_sel (alt_sel),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .irq_mask(irq_mask),
        .clr_mask(clr_mask)
    );

    gpio_edge_flags #(.WIDTH(WIDTH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .level   (pin_lvl),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .clr_mask(clr_mask),
        .flags   (flags)
    );

    gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
        .alt_sel(alt_sel),
        .latch  (latch),
        .dir    (dir),
        .alt_out(alt_out),
        .alt_oe (alt_oe),
        .pad_out(pad_out),
        .pad_oe (pad_oe)
    );

    assign alt_in = pin_lvl;
    assign irq    = |(flags & irq_mask);

    AST_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> pin_lvl == $past(pad_in, 2)
    ) else $error("pin level not two edges behind pad"); // R4

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        flags == '0 |-> !irq
    ) else $error("irq without any flag"); // R9

endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [7:0] pad_in, pad_out, pad_oe;
    logic [7:0] alt_out, alt_oe, alt_in;
    logic       irq;
    logic [7:0] ext;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    // Tristate pad model: driven pins loop back, others follow the external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_edge_port u_gpio_edge_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
        .alt_in(alt_in), .irq(irq)
    );

    typedef struct packed {
        logic [2:0] sel;
        logic [7:0] data;
        logic [7:0] expect_rd;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 8'hA5, 8'hA5},
        '{3'd1, 8'h0F, 8'h0F},
        '{3'd3, 8'h3C, 8'h3C},
        '{3'd4, 8'hFF, 8'hFF},
        '{3'd5, 8'h81, 8'h81},
        '{3'd7, 8'hC3, 8'hC3},
        '{3'd0, 8'h5A, 8'h5A},
        '{3'd1, 8'hF0, 8'hF0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h00;
        ext = 8'h00; alt_out = 8'h00; alt_oe = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        foreach (VECS[k]) begin
            rd(VECS[k].sel, v);
            chk("R1 register reset", v, 8'h00);
        end
        rd(3'd6, v); chk("R1 flags reset", v, 8'h00);

        // R10: table of writes and readbacks
        for (int k = 0; k < 8; k++) begin
            wr(VECS[k].sel, VECS[k].data);
            rd(VECS[k].sel, v);
            chk("R10 readback", v, VECS[k].expect_rd);
        end
        for (int k = 0; k < 8; k++) wr(VECS[k].sel, 8'h00);
        settle(3);
        wr(3'd6, 8'hFF);

        // R2: latch and direction drive the pads
        wr(3'd0, 8'hA5);
        wr(3'd1, 8'hF0);
        chk("R2 pad_out", pad_out, 8'hA5);
        chk("R2 pad_oe", pad_oe, 8'hF0);

        // R3 / R4: latch view vs pin view
        ext = 8'h0F;
        settle(3);
        rd(3'd0, v); chk("R3 latch readback", v, 8'hA5);
        rd(3'd2, v); chk("R4 pin readback", v, 8'hAF);

        // R4: exact two-edge delay
        ext = 8'h0E;
        @(posedge clk); @(negedge clk);
        rd(3'd2, v); chk("R4 one edge old level", v, 8'hAF);
        @(posedge clk); @(negedge clk);
        rd(3'd2, v); chk("R4 two edges new level", v, 8'hAE);

        // R4: writes to pin select ignored
        wr(3'd2, 8'h00);
        rd(3'd0, v); chk("R4 write ignored latch", v, 8'hA5);
        rd(3'd1, v); chk("R4 write ignored dir", v, 8'hF0);
        rd(3'd2, v); chk("R4 write ignored pin", v, 8'hAE);

        // R5: alternate function handoff
        ext = 8'h0F;
        alt_out = 8'h02; alt_oe = 8'h03;
        wr(3'd3, 8'h03);
        chk("R5 pad_oe", pad_oe, 8'hF3);
        chk("R5 pad_out", pad_out, 8'hA6);
        settle(3);
        rd(3'd2, v); chk("R5 pin still tracks", v, 8'hAE);
        chk("R5 alt_in", alt_in, 8'hAE);

        wr(3'd3, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        alt_out = 8'h00; alt_oe = 8'h00;
        ext = 8'h00;
        settle(4);
        wr(3'd6, 8'hFF);

        // R6: edge selection and timing
        wr(3'd4, 8'h05);
        wr(3'd5, 8'h06);
        @(negedge clk); ext = 8'h0F;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3'd6, v); chk("R6 not yet after two edges", v, 8'h00);
        @(posedge clk); @(negedge clk);
        rd(3'd6, v); chk("R6 rising flags", v, 8'h05);
        wr(3'd6, 8'h05);
        rd(3'd6, v); chk("R7 cleared by one", v, 8'h00);
        ext = 8'h00;
        settle(3);
        rd(3'd6, v); chk("R6 falling flags", v, 8'h06);

        // R7: zero bits leave flags; sticky
        wr(3'd6, 8'h00);
        settle(4);
        rd(3'd6, v); chk("R7 zero write keeps", v, 8'h06);
        wr(3'd6, 8'h02);
        rd(3'd6, v); chk("R7 partial clear", v, 8'h04);
        wr(3'd6, 8'h04);
        rd(3'd6, v); chk("R7 full clear", v, 8'h00);

        // R9: interrupt masking
        ext = 8'h01;
        settle(3);
        chk("R9 masked irq low", {7'd0, irq}, 8'h00);
        wr(3'd7, 8'h02);
        chk("R9 other mask irq low", {7'd0, irq}, 8'h00);
        wr(3'd7, 8'h01);
        chk("R9 enabled irq high", {7'd0, irq}, 8'h01);
        wr(3'd6, 8'h01);
        chk("R9 cleared irq low", {7'd0, irq}, 8'h00);

        // R8: set wins over simultaneous clear
        ext = 8'h05;
        settle(3);
        rd(3'd6, v); chk("R8 setup flag", v, 8'h04);
        @(negedge clk); ext = 8'h01;
        @(posedge clk); @(posedge clk);
        wr(3'd6, 8'h04);
        rd(3'd6, v); chk("R8 set beats clear", v, 8'h04);
        wr(3'd6, 8'h04);
        rd(3'd6, v); chk("R8 later clear works", v, 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule